// File: doc/BRIEF.md
# Bit Counting Unit

This unit answers three questions about an operand: how many of its bits are one, how many zero bits sit above its highest one, and how many zero bits sit below its lowest one. Each request carries a 32-bit or 64-bit operand, a size bit and an operation code. The result is held in an output register with a valid flag. The producer side uses a valid/ready handshake. The registered result stays in place until the consumer takes it.

All three counts go through one datapath. A preparation stage selects the operand width and, for the leading-zero count, reverses the bit order. Both zero counts then become a count of the zero bits below the lowest one. A single population counter produces every result. An all-zero operand gives a defined count in every mode. Two flags come with each count: a zero flag for a zero result, and a carry flag that marks an all-zero operand in the two zero-count modes.

Top module: `bitcnt_unit`

## Requirements
- R1: With operation code 0, the count is the number of one bits in the operand within the selected size.
- R2: With operation code 1 and a nonzero operand, the count is the number of zero bits above the most significant one bit, counted from the top bit of the selected size.
- R3: With operation code 2 and a nonzero operand, the count is the number of zero bits below the least significant one bit.
- R4: With operation code 1 or 2 and an operand that is zero within the selected size, the count equals the size: 32 or 64.
- R5: The carry flag is 1 exactly when the operation code is 1 or 2 and the operand is zero within the selected size. It is 0 for a population count.
- R6: The zero flag is 1 exactly when the returned count is zero.
- R7: When `in_wide` is 0 the operand is 32 bits wide, and bits 63:32 of `in_data` have no effect on the count or on the flags.
- R8: A request is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `out_valid` rises at that edge and the result is on the outputs from that edge on. While `out_valid` is 1 and `out_ready` is 0, the result holds steady and `in_ready` stays 0.
- R9: Operation code 3 behaves as a population count.
- R10: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request |
| in_op | input | 2 | 0 population, 1 leading zeros, 2 trailing zeros, 3 population |
| in_wide | input | 1 | 1 selects a 64-bit operand, 0 selects a 32-bit operand |
| in_data | input | 64 | Operand |
| out_valid | output | 1 | Result register holds an unconsumed result |
| out_ready | input | 1 | Consumer takes the result |
| out_count | output | 7 | Count, 0 to 64 |
| out_zf | output | 1 | Count is zero |
| out_cf | output | 1 | Operand zero in a zero-count mode |

## Verification
The handshake assertions assume that the consumer drives `out_ready` as a clean level sampled at the clock edge. They also assume that no request arrives while `rst` is high. The bench changes every input only at falling edges, and it starts requests only after reset is released. Random operands go through a sparsity mask, so all-zero halves, single set bits and dense words all occur. Directed cases cover zero operands, the top and bottom bits, and upper-half garbage in 32-bit mode.

// File: rtl/bitcnt_pkg.sv
package bitcnt_pkg;

    localparam int OPND_W = 64;
    localparam int HALF_W = OPND_W / 2;
    localparam int CNT_W  = $clog2(OPND_W) + 1;

    typedef enum logic [1:0] {
        OP_POP   = 2'd0,
        OP_LEAD  = 2'd1,
        OP_TRAIL = 2'd2,
        OP_POPX  = 2'd3
    } cnt_op_e;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             zf;
        logic             cf;
    } cnt_res_t;

    function automatic logic is_zero_mode(cnt_op_e op);
        return (op == OP_LEAD) || (op == OP_TRAIL);
    endfunction

endpackage

// File: rtl/bitcnt_prep.sv
module bitcnt_prep
    import bitcnt_pkg::*;
#(
    parameter int DATA_W = OPND_W
) (
    input  cnt_op_e           op,
    input  logic              wide,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] vec,
    output logic              all_zero
);

    localparam int HW = DATA_W / 2;

    logic [DATA_W-1:0] narrowed;
    logic [DATA_W-1:0] rev_full;
    logic [DATA_W-1:0] rev_half;
    logic [DATA_W-1:0] oriented;
    logic [DATA_W-1:0] size_mask;
    logic [DATA_W-1:0] below_mask;

    assign narrowed  = wide ? data : {{HW{1'b0}}, data[HW-1:0]};
    assign size_mask = wide ? {DATA_W{1'b1}} : {{HW{1'b0}}, {HW{1'b1}}};

    for (genvar i = 0; i < DATA_W; i++) begin : g_rev_full
        assign rev_full[i] = narrowed[DATA_W-1-i];
    end

    for (genvar i = 0; i < HW; i++) begin : g_rev_half
        assign rev_half[i]    = narrowed[HW-1-i];
        assign rev_half[HW+i] = 1'b0;
    end

    always_comb begin
        if (op == OP_LEAD) oriented = wide ? rev_full : rev_half;
        else               oriented = narrowed;
        below_mask = ~oriented & (oriented - DATA_W'(1)) & size_mask;
        vec        = is_zero_mode(op) ? below_mask : narrowed;
        all_zero   = (narrowed == '0);
    end

    always_comb begin
        AST_VEC_IN_SIZE: assert ((vec & ~size_mask) == '0); // R7
    end

endmodule

// File: rtl/bitcnt_popcount.sv
module bitcnt_popcount #(
    parameter int W     = 64,
    parameter int CNT_W = $clog2(W) + 1
) (
    input  logic [W-1:0]     vec,
    output logic [CNT_W-1:0] count
);

    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + CNT_W'(vec[i]);
        end
    end

endmodule

// File: rtl/bitcnt_unit.sv
module bitcnt_unit
    import bitcnt_pkg::*;
#(
    parameter int DATA_W = OPND_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_op,
    input  logic              in_wide,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CNT_W-1:0]  out_count,
    output logic              out_zf,
    output logic              out_cf
);

    localparam int HW = DATA_W / 2;

    cnt_op_e           op;
    logic [DATA_W-1:0] vec;
    logic              all_zero;
    logic [CNT_W-1:0]  raw_count;
    cnt_res_t          next_res;
    cnt_res_t          res_q;
    logic              accept;

    assign op = cnt_op_e'(in_op);

    bitcnt_prep #(.DATA_W(DATA_W)) u_prep (
        .op       (op),
        .wide     (in_wide),
        .data     (in_data),
        .vec      (vec),
        .all_zero (all_zero)
    );

    bitcnt_popcount #(.W(DATA_W), .CNT_W(CNT_W)) u_pop (
        .vec   (vec),
        .count (raw_count)
    );

    always_comb begin
        next_res.count = raw_count;
        next_res.zf    = (raw_count == '0);
        next_res.cf    = is_zero_mode(op) && all_zero;
    end

    assign in_ready = !out_valid || out_ready;
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_q     <= '0;
        end else if (accept) begin
            out_valid <= 1'b1;
            res_q     <= next_res;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assign out_count = res_q.count;
    assign out_zf    = res_q.zf;
    assign out_cf    = res_q.cf;

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_count) && $stable(out_zf) && $stable(out_cf)); // R8
    AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid); // R8
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_count <= CNT_W'(DATA_W)); // R4
    AST_CF_WIDTH: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_cf |-> (out_count == CNT_W'(HW)) || (out_count == CNT_W'(DATA_W))); // R5
    AST_ZF_EXCL: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_zf |-> !out_cf); // R6

endmodule

// File: tb/test_bitcnt_unit.sv
`timescale 1ns/1ps
module test_bitcnt_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [1:0]  in_op;
    logic        in_wide;
    logic [63:0] in_data;
    logic        out_valid;
    logic        out_ready;
    logic [6:0]  out_count;
    logic        out_zf;
    logic        out_cf;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    bitcnt_unit i_bitcnt_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_wide(in_wide), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_count(out_count), .out_zf(out_zf), .out_cf(out_cf)
    );

    function automatic int ref_count(logic [1:0] op, logic wide, logic [63:0] d);
        int w = wide ? 64 : 32;
        int n = 0;
        if (op == 2'd1) begin
            for (int i = w - 1; i >= 0; i--) begin
                if (d[i]) break;
                n++;
            end
        end else if (op == 2'd2) begin
            for (int i = 0; i < w; i++) begin
                if (d[i]) break;
                n++;
            end
        end else begin
            for (int i = 0; i < w; i++) n += int'(d[i]);
        end
        return n;
    endfunction

    function automatic logic ref_cf(logic [1:0] op, logic wide, logic [63:0] d);
        logic z = wide ? (d == 64'd0) : (d[31:0] == 32'd0);
        return (op == 2'd1 || op == 2'd2) && z;
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(logic [1:0] op, logic wide, logic [63:0] d, int hold, string req);
        int ec = ref_count(op, wide, d);
        @(negedge clk);
        check("R8", in_ready, 1);
        in_valid = 1'b1; in_op = op; in_wide = wide; in_data = d; out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0; in_data = ~d;
        check("R8", out_valid, 1);
        check(req, out_count, ec);
        check("R6", out_zf, ec == 0);
        check("R5", out_cf, ref_cf(op, wide, d));
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check("R8", in_ready, 0);
            check("R8", out_valid, 1);
            check("R8", out_count, ec);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check("R8", out_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b0; in_op = 2'd0; in_wide = 1'b1;
        in_data = '0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10", out_valid, 0);
        check("R10", in_ready, 1);

        run(2'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R1");
        run(2'd0, 1'b1, 64'd0, 1, "R1");
        run(2'd1, 1'b1, 64'h8000_0000_0000_0000, 0, "R2");
        run(2'd1, 1'b1, 64'h0000_0000_0000_0001, 2, "R2");
        run(2'd2, 1'b1, 64'h8000_0000_0000_0000, 0, "R3");
        run(2'd2, 1'b1, 64'h0000_0000_0001_0000, 0, "R3");
        run(2'd1, 1'b1, 64'd0, 0, "R4");
        run(2'd2, 1'b1, 64'd0, 0, "R4");
        run(2'd1, 1'b0, 64'hDEAD_BEEF_0000_0000, 1, "R4");
        run(2'd2, 1'b0, 64'hFFFF_FFFF_0000_0000, 0, "R4");
        run(2'd0, 1'b0, 64'hFFFF_FFFF_0000_0003, 0, "R7");
        run(2'd1, 1'b0, 64'hFFFF_0000_0000_8000, 0, "R7");
        run(2'd2, 1'b0, 64'h0000_0001_8000_0000, 0, "R7");
        run(2'd3, 1'b1, 64'h0F0F_0000_0000_00F1, 0, "R9");
        run(2'd3, 1'b0, 64'h1111_1111_0000_0007, 0, "R9");

        for (int n = 0; n < 400; n++) begin
            logic [63:0] d, m;
            logic [1:0]  op;
            logic        wide;
            string       tag;
            d    = {$urandom, $urandom};
            m    = {$urandom, $urandom} & {$urandom, $urandom};
            case ($urandom_range(0, 3))
                0: d = d & m;
                1: d = d & m & {$urandom, $urandom};
                2: d = 64'd1 << $urandom_range(0, 63);
                default: ;
            endcase
            op   = 2'($urandom_range(0, 3));
            wide = 1'($urandom_range(0, 1));
            if (op == 2'd1) tag = "R2";
            else if (op == 2'd2) tag = "R3";
            else if (op == 2'd3) tag = "R9";
            else tag = "R1";
            if (!wide) tag = "R7";
            run(op, wide, d, $urandom_range(0, 2), tag);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule